// File: doc/BRIEF.md
# Banked Four-Read Register File

This block is a 16-entry, 32-bit register file with one write port and four fully independent read ports. It keeps two identical storage copies. Each write goes to both copies at the same address, so their contents never differ. Each copy serves two of the four read ports. A processor pipeline uses it as its architectural register set: operand fetch drives the four read addresses, and write-back drives the single write port.

Each copy is twice as deep as the register set. A one-bit bank select picks which half is live. Software or an interrupt controller can therefore swap the whole register set in a single cycle, for example on entering or leaving an interrupt handler, without any copying. Reads are combinational from the address. A write in the current cycle is forwarded to any read port that addresses the same register, so a reader always sees the newest value.

Top module: `rf_banked_4r1w`

## Requirements
- R1: After reset, every register in both banks reads as zero, and the active bank is bank 0.
- R2: When `wr_en` is high at a rising clock edge, `wr_data` is stored in register `wr_addr` of the active bank. From the next cycle on, every read port that addresses that register returns it.
- R3: Each read port returns the contents of the register at its own address in the active bank, independently of the other ports. Port i uses `rd_addr[i]` and drives `rd_data[i]`, with each address 4 bits wide.
- R4: In a cycle where `wr_en` is high and a read port's address equals `wr_addr`, that port returns `wr_data` in the same cycle.
- R5: When `wr_en` is low, no register in either bank changes, whatever `wr_addr` and `wr_data` hold.
- R6: `bank_sel` is sampled at each rising clock edge and becomes the active bank for reads and writes from the next cycle. The value 0 selects bank 0 and the value 1 selects bank 1. A switch completes in one cycle.
- R7: A write into the active bank leaves the register with the same index in the other bank unchanged.
- R8: Read ports served by different storage copies (ports 0 and 1 from one copy, ports 2 and 3 from the other) return identical data when given the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 1 | Requested bank, takes effect on the next cycle |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Register index to write |
| wr_data | input | 32 | Data to write |
| rd_addr | input | 4x4 | Register index per read port, packed [port][index] |
| rd_data | output | 4x32 | Read data per port, packed [port][data] |

## Verification
The hardest case to reach from the ports is a write in one bank that must not touch the same index in the other bank. A wrong bank bit would only show up once the bank switches back. The stimulus fills bank 1 with a known pattern, then writes every index of bank 0, then swaps back and reads all of bank 1. Combined bypass and bank cases are also covered. The bench writes in the cycle where `bank_sel` changes and checks that the write lands in the old bank. It also aims ports on different copies at the same address while a write to that address is in flight.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_ALT  = 1'b1
    } bank_e;

endpackage

// File: rtl/rf_bank_ctl.sv
module rf_bank_ctl
    import rf_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bank_req,
    output bank_e bank_o
);

    typedef struct packed {
        bank_e bank;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bank = bank_e'(bank_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bank: BANK_MAIN};
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o = st_q.bank;

    // R6: a differing request produces a swap on the very next edge
    a_r6_swap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req != st_q.bank) |=> (st_q.bank != $past(st_q.bank)));

endmodule

// File: rtl/rf_copy.sv
module rf_copy #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    parameter int NRD  = 2,
    localparam int DEPTH = 2 * NREG,
    localparam int FAW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [FAW-1:0]           wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [NRD-1:0][FAW-1:0]  rd_addr,
    output logic [NRD-1:0][DW-1:0]   rd_data
);

    localparam logic [FAW-1:0] BANK_FLIP = FAW'(NREG);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } copy_state_t;

    copy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic hit;
        assign hit        = wr_en && (wr_addr == rd_addr[p]);
        assign rd_data[p] = hit ? wr_data : st_q.mem[rd_addr[p]];
    end

    // R2: written word is present after the edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.mem[$past(wr_addr)] == $past(wr_data)));

    // R5: no enable, no change anywhere
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.mem));

    // R7: the twin entry in the other bank is untouched by a write
    a_r7_other_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.mem[$past(wr_addr) ^ BANK_FLIP] ==
                   $past(st_q.mem[wr_addr ^ BANK_FLIP])));

endmodule

// File: rtl/rf_banked_4r1w.sv
module rf_banked_4r1w
    import rf_bank_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 16,
    parameter int NCOPY = 2,
    parameter int RPC   = 2,
    localparam int NRD  = NCOPY * RPC,
    localparam int AW   = $clog2(NREG),
    localparam int FAW  = AW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bank_sel,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    output logic [NRD-1:0][DW-1:0]  rd_data
);

    bank_e          bank_q;
    logic [FAW-1:0] wr_full;

    rf_bank_ctl u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_req (bank_sel),
        .bank_o   (bank_q)
    );

    assign wr_full = {bank_q, wr_addr};

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        logic [RPC-1:0][FAW-1:0] rd_full;
        logic [RPC-1:0][DW-1:0]  rd_word;

        for (genvar p = 0; p < RPC; p++) begin : g_port
            assign rd_full[p]         = {bank_q, rd_addr[c*RPC + p]};
            assign rd_data[c*RPC + p] = rd_word[p];
        end

        rf_copy #(
            .DW   (DW),
            .NREG (NREG),
            .NRD  (RPC)
        ) u_copy (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_full),
            .wr_data (wr_data),
            .rd_addr (rd_full),
            .rd_data (rd_word)
        );

        if (c > 0) begin : g_agree
            // R8: separate copies agree on equal addresses
            a_r8_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_addr[c*RPC] == rd_addr[0]) |-> (rd_data[c*RPC] == rd_data[0]));
        end
    end

    // R1: first cycle out of reset reads zero on every port
    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !wr_en) |-> (rd_data == '0));

endmodule

// File: tb/test_rf_banked_4r1w.sv
`timescale 1ns/1ps
module test_rf_banked_4r1w;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bank_sel = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [3:0][3:0]   rd_addr = '0;
    logic [3:0][31:0]  rd_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [2][16];
    int bank_m = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rf_banked_4r1w i_rf_banked_4r1w (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_sel (bank_sel),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    task automatic check_ports(input string tag);
        for (int p = 0; p < 4; p++) begin
            logic [31:0] exp;
            string t;
            t = tag;
            if (wr_en && wr_addr == rd_addr[p]) begin
                exp = wr_data;
                t = {tag, "/R4"};
            end else begin
                exp = model[bank_m][rd_addr[p]];
            end
            checks++;
            if (rd_data[p] !== exp) begin
                failures++;
                $display("FAIL %s port%0d addr=%0d bank=%0d actual=%h expected=%h",
                         t, p, rd_addr[p], bank_m, rd_data[p], exp);
            end
        end
    endtask

    // one cycle: inputs already set after a falling edge
    task automatic step(input string tag);
        #8;
        check_ports(tag);
        @(posedge clk);
        #1;
        if (wr_en) model[bank_m][wr_addr] = wr_data;
        bank_m = int'(bank_sel);
        @(negedge clk);
    endtask

    task automatic set_in(input bit we, input int wa, input logic [31:0] wd,
                          input int a0, input int a1, input int a2, input int a3,
                          input bit bs);
        wr_en    = we;
        wr_addr  = 4'(wa);
        wr_data  = wd;
        rd_addr[0] = 4'(a0);
        rd_addr[1] = 4'(a1);
        rd_addr[2] = 4'(a2);
        rd_addr[3] = 4'(a3);
        bank_sel = bs;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 16; r++) model[b][r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: both banks zero after reset
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < 16; r += 4) begin
                set_in(0, 0, 32'hFFFF_FFFF, r, r+1, r+2, r+3, b[0]);
                step("R1");
            end
            set_in(0, 0, 0, 0, 1, 2, 3, b[0] ^ 1'b1);
            step("R1");
        end

        // R2: fill bank 0, then read back
        for (int r = 0; r < 16; r++) begin
            set_in(1, r, 32'hA500_0000 + 32'(r * 17), (r+1)%16, (r+5)%16, (r+9)%16, (r+13)%16, 0);
            step("R2");
        end
        for (int r = 0; r < 16; r += 4) begin
            set_in(0, 0, 0, r, r+1, r+2, r+3, 0);
            step("R2");
        end

        // R4: bypass on every port
        for (int i = 0; i < 8; i++) begin
            set_in(1, i, $urandom, i, i, (i+3)%16, i, 0);
            step("R4");
        end

        // R5: disabled writes leave everything unchanged
        for (int i = 0; i < 8; i++) begin
            set_in(0, i*2, $urandom, i*2, (i*2+1)%16, i, 15-i, 0);
            step("R5");
        end

        // R6/R7: write bank 1, then bank 0 full, then bank 1 must be intact
        set_in(0, 0, 0, 0, 1, 2, 3, 1);
        step("R6");
        for (int r = 0; r < 16; r++) begin
            set_in(1, r, 32'h1B00_0000 + 32'(r), r, 0, 0, 0, 1);
            step("R6");
        end
        set_in(1, 5, 32'hCAFE_0005, 5, 5, 6, 7, 0);   // write in switch cycle lands in bank 1
        step("R6");
        for (int r = 0; r < 16; r++) begin
            set_in(1, r, 32'h0C00_0000 + 32'(r), (r+1)%16, r, 3, 4, 0);
            step("R7");
        end
        set_in(0, 0, 0, 0, 1, 2, 3, 1);
        step("R6");
        for (int r = 0; r < 16; r += 4) begin
            set_in(0, 0, 0, r, r+1, r+2, r+3, 1);
            step("R7");
        end
        set_in(0, 0, 0, 0, 1, 2, 3, 0);
        step("R6");
        step("R6");

        // R3: random independent addresses, random writes and banks
        for (int i = 0; i < 300; i++) begin
            set_in($urandom_range(0, 1), $urandom_range(0, 15), $urandom,
                   $urandom_range(0, 15), $urandom_range(0, 15),
                   $urandom_range(0, 15), $urandom_range(0, 15),
                   ($urandom_range(0, 7) == 0) ? ~bank_sel : bank_sel);
            step("R3");
        end

        // R8: ports on different copies given the same address
        for (int i = 0; i < 32; i++) begin
            int a;
            a = i % 16;
            set_in(i[0], a, $urandom, a, (a+1)%16, a, (a+2)%16, i[4]);
            step("R8");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule